// File: doc/BRIEF.md
# Dual-Channel Power Sequencer

This block decides when each of two regulator channels is asked to run. Each channel is requested by an enable pin and a software enable bit. A two-bit mode selects one of three behaviours. The channels can follow their own requests. They can start in cascade in either order and stop in the reverse order. They can also start and stop together. In cascade the second channel starts only after the first one reports power-good and a programmable delay has passed. At power-down the same delay separates the two channels, in reverse order.

A per-channel run output starts or stops that channel's soft ramp. A registered chip-state output reports shutdown, standby or active. Delays are counted in a 1 µs tick enable supplied by the surrounding logic. Mode and delay settings are captured only while both channels are off and no sequence is in progress. Fault flags drop the affected channel. In a sequenced mode they drop both channels.

Top module: `pwr_seq_top`

## Requirements
- R1: `chip_state_o` is registered one clock after the inputs. It is 2'b00 (shutdown) when both enable pins are low. It is 2'b10 (active) when some channel has both its pin and its bit high. Otherwise it is 2'b01 (standby).
- R2: In mode 2'b00, `run_o[k]` equals `en_pin_i[k] & en_bit_i[k] & ~fault_i[k]` one clock later, for each channel on its own.
- R3: In mode 2'b01, a pair request (both channels requested, no fault) raises `run_o[0]` one clock later. `run_o[1]` rises D tick-counted clocks after the clock at which `pgood_i[0]` is first sampled high while `run_o[0]` is up. Counted from the input change, that is D+1 clocks.
- R4: In a cascaded mode, withdrawing the pair request drops the trailing channel one clock later. The block then waits until the trailing power-good is low or D ticks have passed, then counts D more ticks, and then drops the leading channel. With the power-good held high this is 2D+1 clocks after the withdrawal. With the power-good falling at the withdrawal it is D+2 clocks.
- R5: Mode 2'b10 behaves as R3 and R4 with ch1 leading and ch0 trailing.
- R6: In mode 2'b11, both `run_o` bits rise together one clock after a pair request and fall together one clock after it ends. A single-channel request runs nothing.
- R7: `seq_dly_i` codes 00/01/10/11 select D = `DLY_C0_TICKS`/`DLY_C1_TICKS`/`DLY_C2_TICKS`/`DLY_C3_TICKS`. The defaults are 1500/12500/25000/50000 ticks of 1 µs.
- R8: In any mode other than 2'b00, a high bit on `fault_i` clears both `run_o` bits on the next clock. In mode 2'b00 a fault clears only its own channel.
- R9: A change of `seq_mode_i` or `seq_dly_i` has no effect while any `run_o` bit is high or a sequence is in progress. The new setting takes effect once both are off and idle.
- R10: If the pair request is withdrawn before the trailing channel has started, the leading channel drops one clock later.
- R11: The delay counters advance only on clocks where `tick_i` is high. With `tick_i` low the trailing channel never starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 µs delay tick enable |
| en_pin_i | input | 2 | Per-channel enable pins |
| en_bit_i | input | 2 | Per-channel enable register bits |
| seq_mode_i | input | 2 | 00 independent, 01 ch0 leads, 10 ch1 leads, 11 together |
| seq_dly_i | input | 2 | Sequence delay code |
| pgood_i | input | 2 | Per-channel power-good comparator flags |
| fault_i | input | 2 | Per-channel fault flags |
| run_o | output | 2 | Per-channel run request |
| chip_state_o | output | 2 | 00 shutdown, 01 standby, 10 active |

## Verification
The chip-state decode is swept over all sixteen pin and bit combinations, and mode 00 over all 64 pin, bit and fault combinations, which separates per-channel gating from pair gating. Both cascade orders are run with every delay code. Odd codes end with the trailing power-good falling and even codes with it held high, so each case is timed to the exact clock and the power-good exit is told apart from the timeout exit. Further cases cover joint start, fault collapse in sequenced and independent modes, a mode change made while a channel runs, withdrawal before the trailing channel starts, and a stalled tick.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    CHIP_OFF  = 2'b00,
    CHIP_STBY = 2'b01,
    CHIP_ACT  = 2'b10
  } chip_state_e;

  typedef enum logic [1:0] {
    MODE_INDEP = 2'b00,
    MODE_0_LEAD = 2'b01,
    MODE_1_LEAD = 2'b10,
    MODE_JOINT = 2'b11
  } seq_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD_UP,
    SQ_ON_WAIT,
    SQ_BOTH,
    SQ_TRAIL_DN,
    SQ_OFF_WAIT
  } seq_st_e;
endpackage

// File: rtl/pwr_seq_chip_state.sv
module pwr_seq_chip_state
  import pwr_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  en_pin_i,
  input  logic [1:0]  en_bit_i,
  output logic [1:0]  want_o,
  output chip_state_e state_o
);
  chip_state_e state_d, state_q;

  assign want_o = en_pin_i & en_bit_i;

  always_comb begin
    if (en_pin_i == 2'b00)   state_d = CHIP_OFF;
    else if (|want_o)        state_d = CHIP_ACT;
    else                     state_d = CHIP_STBY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CHIP_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_state_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11);
  p_active_has_want_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|want_o) |=> (state_q == CHIP_ACT));
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == lim_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_i));
  p_tick_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_seq_casc.sv
module pwr_seq_casc
  import pwr_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    active_i,
  input  logic    req_i,
  input  logic    fault_i,
  input  logic    pg_lead_i,
  input  logic    pg_trail_i,
  input  logic    done_i,
  output seq_st_e st_q_o,
  output seq_st_e st_d_o,
  output logic    clr_o,
  output logic    cnt_run_o
);
  seq_st_e st_d, st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:     if (active_i && req_i) st_d = SQ_LEAD_UP;
      SQ_LEAD_UP:  if (fault_i || !req_i) st_d = SQ_IDLE;
                   else if (pg_lead_i)    st_d = SQ_ON_WAIT;
      SQ_ON_WAIT:  if (fault_i || !req_i) st_d = SQ_IDLE;
                   else if (done_i)       st_d = SQ_BOTH;
      SQ_BOTH:     if (fault_i)           st_d = SQ_IDLE;
                   else if (!req_i)       st_d = SQ_TRAIL_DN;
      SQ_TRAIL_DN: if (fault_i)           st_d = SQ_IDLE;
                   else if (!pg_trail_i || done_i) st_d = SQ_OFF_WAIT;
      SQ_OFF_WAIT: if (fault_i || done_i) st_d = SQ_IDLE;
      default:     st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

  assign st_q_o    = st_q;
  assign st_d_o    = st_d;
  assign clr_o     = (st_d != st_q);
  assign cnt_run_o = (st_q == SQ_ON_WAIT) || (st_q == SQ_TRAIL_DN) ||
                     (st_q == SQ_OFF_WAIT);

  p_fault_to_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (st_q == SQ_IDLE));
  p_no_skip_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_IDLE) |=> (st_q == SQ_IDLE || st_q == SQ_LEAD_UP));
  p_trail_before_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_BOTH) |=> (st_q == SQ_BOTH || st_q == SQ_TRAIL_DN || st_q == SQ_IDLE));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int DLY_C0_TICKS = 1500,
  parameter int DLY_C1_TICKS = 12500,
  parameter int DLY_C2_TICKS = 25000,
  parameter int DLY_C3_TICKS = 50000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] en_pin_i,
  input  logic [1:0] en_bit_i,
  input  logic [1:0] seq_mode_i,
  input  logic [1:0] seq_dly_i,
  input  logic [1:0] pgood_i,
  input  logic [1:0] fault_i,
  output logic [1:0] run_o,
  output logic [1:0] chip_state_o
);
  localparam int DLY_M01 = (DLY_C0_TICKS > DLY_C1_TICKS) ? DLY_C0_TICKS : DLY_C1_TICKS;
  localparam int DLY_M23 = (DLY_C2_TICKS > DLY_C3_TICKS) ? DLY_C2_TICKS : DLY_C3_TICKS;
  localparam int DLY_MAX = (DLY_M01 > DLY_M23) ? DLY_M01 : DLY_M23;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  function automatic logic [CNT_W-1:0] lim_of(input logic [1:0] code);
    case (code)
      2'd0:    lim_of = CNT_W'(DLY_C0_TICKS);
      2'd1:    lim_of = CNT_W'(DLY_C1_TICKS);
      2'd2:    lim_of = CNT_W'(DLY_C2_TICKS);
      default: lim_of = CNT_W'(DLY_C3_TICKS);
    endcase
  endfunction

  logic [1:0]  want;
  chip_state_e chip_st;
  seq_st_e     st_q, st_d;
  logic        clr, cnt_run, done;
  logic [1:0]  run_q, run_d;
  seq_mode_e   mode_q, mode_eff;
  logic [1:0]  dly_q, dly_eff;
  logic        idle_all, flt_any, grp_ok, casc, lead1, pg_lead, pg_trail;
  logic        lead_on, trail_on;

  pwr_seq_chip_state u_chip (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_pin_i (en_pin_i),
    .en_bit_i (en_bit_i),
    .want_o   (want),
    .state_o  (chip_st)
  );

  // settings are frozen while anything runs or a sequence is mid-flight
  assign idle_all = (run_q == 2'b00) && (st_q == SQ_IDLE);
  assign mode_eff = idle_all ? seq_mode_e'(seq_mode_i) : mode_q;
  assign dly_eff  = idle_all ? seq_dly_i : dly_q;

  assign flt_any  = |fault_i;
  assign grp_ok   = want[0] && want[1] && !flt_any;
  assign casc     = (mode_eff == MODE_0_LEAD) || (mode_eff == MODE_1_LEAD);
  assign lead1    = (mode_eff == MODE_1_LEAD);
  assign pg_lead  = lead1 ? pgood_i[1] : pgood_i[0];
  assign pg_trail = lead1 ? pgood_i[0] : pgood_i[1];

  pwr_seq_casc u_casc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (casc),
    .req_i      (grp_ok),
    .fault_i    (flt_any),
    .pg_lead_i  (pg_lead),
    .pg_trail_i (pg_trail),
    .done_i     (done),
    .st_q_o     (st_q),
    .st_d_o     (st_d),
    .clr_o      (clr),
    .cnt_run_o  (cnt_run)
  );

  pwr_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (cnt_run),
    .tick_i (tick_i),
    .lim_i  (lim_of(dly_eff)),
    .done_o (done)
  );

  assign lead_on  = (st_d != SQ_IDLE);
  assign trail_on = (st_d == SQ_BOTH);

  always_comb begin
    unique case (mode_eff)
      MODE_INDEP:  run_d = want & ~fault_i;
      MODE_JOINT:  run_d = {2{grp_ok}};
      MODE_0_LEAD: run_d = {trail_on, lead_on};
      default:     run_d = {lead_on, trail_on};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 2'b00;
      mode_q <= MODE_INDEP;
      dly_q  <= 2'b00;
    end else begin
      run_q  <= run_d;
      mode_q <= mode_eff;
      dly_q  <= dly_eff;
    end
  end

  assign run_o        = run_q;
  assign chip_state_o = chip_st;

  p_indep_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == MODE_INDEP) |=> (run_q == $past(want & ~fault_i)));
  p_order01_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_0_LEAD && run_q[1]) |-> run_q[0]);
  p_order10_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_1_LEAD && run_q[0]) |-> run_q[1]);
  p_joint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_JOINT) |-> (run_q[0] == run_q[1]));
  p_fault_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff != MODE_INDEP && flt_any) |=> (run_q == 2'b00));
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|run_q) |=> $stable(mode_q) && $stable(dly_q));
endmodule

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] pin = '0, bits = '0, mode = '0, dly = '0, pg = '0, flt = '0;
  logic [1:0] run_o, chip_state_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwr_seq_top #(
    .DLY_C0_TICKS(2), .DLY_C1_TICKS(3), .DLY_C2_TICKS(4), .DLY_C3_TICKS(5)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .en_pin_i(pin), .en_bit_i(bits), .seq_mode_i(mode), .seq_dly_i(dly),
    .pgood_i(pg), .fault_i(flt), .run_o(run_o), .chip_state_o(chip_state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_run(input int ch, input logic v, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (run_o[ch] !== v && n < 300);
  endtask

  task automatic settle();
    pin = 2'b00; bits = 2'b00; pg = 2'b00; flt = 2'b00; tick = 1'b1;
    cyc(20);
    mode = 2'b00;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, n2, ld, tr, lim;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset chip state", chip_state_o, 0);
    chk("R2 reset run", run_o, 0);

    // R1 chip state sweep
    for (int i = 0; i < 16; i++) begin
      int e;
      pin = i[1:0]; bits = i[3:2];
      cyc(1);
      if (pin == 2'b00) e = 0;
      else if ((pin & bits) != 2'b00) e = 2;
      else e = 1;
      chk($sformatf("R1 pins=%0d bits=%0d", pin, bits), chip_state_o, e);
    end
    settle();

    // R2 independent mode sweep
    for (int i = 0; i < 64; i++) begin
      pin = i[1:0]; bits = i[3:2]; flt = i[5:4];
      cyc(1);
      chk($sformatf("R2 combo %0d", i), run_o, int'(pin & bits & ~flt));
    end
    settle();

    // R3 R4 R5 R7 cascade sweep over orders and delay codes
    for (int m = 1; m <= 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        ld = (m == 1) ? 0 : 1;
        tr = 1 - ld;
        lim = c + 2;
        mode = m[1:0]; dly = c[1:0]; pin = 2'b11; bits = 2'b11;
        wait_run(ld, 1'b1, n);
        chk($sformatf("R3 R5 lead up m=%0d", m), n, 1);
        cyc(4);
        chk("R3 R5 trail waits for lead pgood", run_o[tr], 0);
        pg[ld] = 1'b1;
        wait_run(tr, 1'b1, n);
        chk($sformatf("R7 trail delay m=%0d code=%0d", m, c), n, lim + 1);
        pg[tr] = 1'b1;
        cyc(3);
        bits = 2'b00;
        if (c % 2 == 1) pg[tr] = 1'b0;
        cyc(1);
        chk("R4 trail drops first", run_o[tr], 0);
        chk("R4 lead still on", run_o[ld], 1);
        wait_run(ld, 1'b0, n2);
        chk($sformatf("R4 R5 lead off m=%0d code=%0d", m, c), 1 + n2,
            (c % 2 == 1) ? lim + 2 : 2 * lim + 1);
        settle();
      end
    end

    // R6 joint mode
    mode = 2'b11; pin = 2'b11; bits = 2'b01;
    cyc(3);
    chk("R6 single request runs nothing", run_o, 0);
    bits = 2'b11;
    cyc(1);
    chk("R6 joint start", run_o, 3);
    bits = 2'b10;
    cyc(1);
    chk("R6 joint stop", run_o, 0);
    bits = 2'b11;
    cyc(2);
    flt = 2'b01;
    cyc(1);
    chk("R8 joint fault", run_o, 0);
    settle();

    // R8 fault in cascade mode
    mode = 2'b01; dly = 2'b00; pin = 2'b11; bits = 2'b11; pg = 2'b11;
    cyc(6);
    chk("R8 cascade up", run_o, 3);
    flt = 2'b10;
    cyc(1);
    chk("R8 cascade fault drops both", run_o, 0);
    cyc(3);
    chk("R8 fault held", run_o, 0);
    settle();

    // R8 fault in independent mode
    mode = 2'b00; pin = 2'b11; bits = 2'b11;
    cyc(2);
    flt = 2'b10;
    cyc(1);
    chk("R8 indep fault own channel", run_o, 1);
    settle();

    // R9 deferred mode change
    mode = 2'b00; pin = 2'b11; bits = 2'b01;
    cyc(2);
    chk("R9 indep ch0 only", run_o, 1);
    mode = 2'b01; bits = 2'b11;
    cyc(1);
    chk("R9 old mode kept while running", run_o, 3);
    bits = 2'b00;
    cyc(1);
    chk("R9 both off", run_o, 0);
    bits = 2'b11;
    cyc(5);
    chk("R9 new mode after idle", run_o, 1);
    settle();

    // R10 withdraw before trailing start
    mode = 2'b10; dly = 2'b01; pin = 2'b11; bits = 2'b11;
    cyc(2);
    chk("R10 lead ch1 up", run_o, 2);
    bits = 2'b01;
    cyc(1);
    chk("R10 lead drops", run_o, 0);
    settle();

    // R11 tick gating
    mode = 2'b01; dly = 2'b11; pin = 2'b11; bits = 2'b11; tick = 1'b0;
    cyc(2);
    pg = 2'b01;
    cyc(40);
    chk("R11 no tick no trail", run_o, 1);
    tick = 1'b1;
    wait_run(1, 1'b1, n);
    chk("R11 trail after ticks resume", n, 5);
    settle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule